// File: doc/BRIEF.md
# Offset Window Slice Selector

This block picks one fixed-width slice out of a wide input vector in a single combinational path. A parameter fixes where the first slice begins inside the input, and a select input chooses which slice appears at the output. Slice `k` starts at input bit `START + k*SLICE_W`, and each higher output bit takes the next higher input bit.

The select input can take every one of its `2**SEL_W` codes, including codes whose window runs past the top of the input. To make that safe, input positions at or beyond `DATA_W` read as zero. A slice that straddles the top of the input therefore returns its low bits from the input and zeros above them. A slice that starts beyond the top returns all zeros.

With the default parameters (250-bit input, 10-bit slice, 5-bit select, offset 27), select 21 is the last full slice (input bits 237..246). Select 22 is partial: its three low bits come from input bits 247..249. Selects 23 to 31 give zero.

Top module: `offset_slice_select`

## Requirements
- R1: Output bit `j` equals input bit `START + sel*SLICE_W + j` whenever that index is below `DATA_W`; `sel` is read as an unsigned number, so with the defaults sel=0 returns input bits 27..36 with bit 27 at output bit 0.
- R2: Output bits whose input index is at or beyond `DATA_W` read 0, so with the defaults sel=22 returns input bits 247..249 in output bits 0..2 and zeros in output bits 3..9.
- R3: A select whose window starts at or beyond `DATA_W` gives an all-zero output, whatever the input holds (sel=23..31 with the defaults).
- R4: Every select code from 0 to `2**SEL_W-1` produces a fully known output for any known input.
- R5: Input bits outside the selected window have no effect on the output.
- R6: Input bits below `START` never reach the output for any select value.
- R7: The output follows a change of either input within the same clock cycle, with no register on the path.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| data_in | input | DATA_W | Wide source vector |
| sel | input | SEL_W | Unsigned slice index |
| slice_out | output | SLICE_W | Selected slice, zero-filled past the input top |

## Verification
A wrong lane boundary or a wrong offset shows on the very next output sample. It appears as slice bits shifted by one or more positions against the bit-level model, or as a bit taken from the neighbouring slice. A fault in the zero-fill shows only for the straddling select and the fully out-of-range selects, as stray ones or unknowns in bits that must read zero. The bench therefore sweeps those codes with random data, and it also flips data outside one window to show that the output does not move.

// File: rtl/slice_sel_pkg.sv
package slice_sel_pkg;

    // Number of selectable lanes for a select of the given width.
    function automatic int lane_count(input int sel_w);
        return 1 << sel_w;
    endfunction

    // Width of the zero-extended window vector that holds all lanes.
    function automatic int span_width(input int slice_w, input int sel_w);
        return slice_w * lane_count(sel_w);
    endfunction

    // First input bit covered by lane k.
    function automatic int lane_base(input int start, input int slice_w, input int k);
        return start + k * slice_w;
    endfunction

endpackage

// File: rtl/slice_extend.sv
module slice_extend
    import slice_sel_pkg::*;
#(
    parameter int DATA_W = 250,
    parameter int SPAN_W = 320,
    parameter int START  = 27
) (
    input  logic [DATA_W-1:0] data_in,
    output logic [SPAN_W-1:0] span
);

    // Pure wiring: each span bit is either an input bit or a constant zero.
    for (genvar i = 0; i < SPAN_W; i++) begin : g_bit
        if (i + START < DATA_W) begin : g_live
            assign span[i] = data_in[i + START];
        end else begin : g_fill
            assign span[i] = 1'b0;
        end
    end

endmodule

// File: rtl/slice_lanes.sv
module slice_lanes
    import slice_sel_pkg::*;
#(
    parameter int SLICE_W = 10,
    parameter int LANES   = 32
) (
    input  logic [SLICE_W*LANES-1:0]          span,
    output logic [LANES-1:0][SLICE_W-1:0]     lanes
);

    // Regroup the flat span into consecutive lanes; no gates are implied.
    for (genvar k = 0; k < LANES; k++) begin : g_lane
        assign lanes[k] = span[k*SLICE_W +: SLICE_W];
    end

endmodule

// File: rtl/slice_mux.sv
module slice_mux
    import slice_sel_pkg::*;
#(
    parameter int SLICE_W = 10,
    parameter int SEL_W   = 5,
    localparam int LANES  = 1 << SEL_W
) (
    input  logic [LANES-1:0][SLICE_W-1:0] lanes,
    input  logic [SEL_W-1:0]              sel,
    output logic [SLICE_W-1:0]            slice_out
);

    // The lane array is exactly 2**SEL_W deep, so every code hits a real lane.
    always_comb begin
        slice_out = lanes[sel];
    end

endmodule

// File: rtl/offset_slice_select.sv
module offset_slice_select
    import slice_sel_pkg::*;
#(
    parameter int DATA_W  = 250,
    parameter int SLICE_W = 10,
    parameter int SEL_W   = 5,
    parameter int START   = 27
) (
    input  logic [DATA_W-1:0]  data_in,
    input  logic [SEL_W-1:0]   sel,
    output logic [SLICE_W-1:0] slice_out
);

    localparam int LANES  = lane_count(SEL_W);
    localparam int SPAN_W = span_width(SLICE_W, SEL_W);

    logic [SPAN_W-1:0]              span;
    logic [LANES-1:0][SLICE_W-1:0]  lanes;

    slice_extend #(
        .DATA_W (DATA_W),
        .SPAN_W (SPAN_W),
        .START  (START)
    ) u_extend (
        .data_in (data_in),
        .span    (span)
    );

    slice_lanes #(
        .SLICE_W (SLICE_W),
        .LANES   (LANES)
    ) u_lanes (
        .span  (span),
        .lanes (lanes)
    );

    slice_mux #(
        .SLICE_W (SLICE_W),
        .SEL_W   (SEL_W)
    ) u_mux (
        .lanes     (lanes),
        .sel       (sel),
        .slice_out (slice_out)
    );

    // Port-level checks: the window position is recomputed from sel and
    // compared against what the extend/lane/mux chain delivered.
    int                  chk_base;
    int                  chk_valid;
    logic [DATA_W-1:0]   chk_shift;
    logic [SLICE_W-1:0]  chk_mask;

    always_comb begin
        chk_base  = lane_base(START, SLICE_W, int'(sel));
        chk_shift = data_in >> chk_base;
        if (chk_base >= DATA_W)
            chk_valid = 0;
        else if (DATA_W - chk_base >= SLICE_W)
            chk_valid = SLICE_W;
        else
            chk_valid = DATA_W - chk_base;
        chk_mask = (SLICE_W'(1) << chk_valid) - SLICE_W'(1);

        assert_window_bits_R1: assert ((slice_out & chk_mask) ==
                                       (chk_shift[SLICE_W-1:0] & chk_mask))
            else $error("window bits differ from input at base %0d", chk_base);

        assert_top_fill_zero_R2: assert ((slice_out & ~chk_mask) == '0)
            else $error("bits past input top not zero at base %0d", chk_base);

        if (chk_base >= DATA_W) begin
            assert_far_lane_zero_R3: assert (slice_out == '0)
                else $error("out-of-range lane not zero, sel %0d", sel);
        end

        assert_popcount_bound_R5: assert ($countones(slice_out) <= $countones(data_in))
            else $error("output carries more ones than the input");
    end

endmodule

// File: tb/test_offset_slice_select.sv
module test_offset_slice_select;

    localparam int DW    = 250;
    localparam int SW    = 10;
    localparam int SELW  = 5;
    localparam int ST    = 27;
    localparam int NSEL  = 1 << SELW;

    logic           clk = 1'b0;
    logic           rst = 1'b1;
    logic [DW-1:0]  data_in = '0;
    logic [SELW-1:0] sel = '0;
    logic [SW-1:0]  slice_out;

    int vec_count  = 0;
    int miss_count = 0;
    bit done       = 1'b0;

    always #10 clk = ~clk;   // 50 MHz

    offset_slice_select #(
        .DATA_W (DW),
        .SLICE_W(SW),
        .SEL_W  (SELW),
        .START  (ST)
    ) i_offset_slice_select (
        .data_in   (data_in),
        .sel       (sel),
        .slice_out (slice_out)
    );

    // Bit-level reference: walk output bits from the top down.
    function automatic logic [SW-1:0] ref_slice(input logic [DW-1:0] d, input int s);
        logic [SW-1:0] r;
        logic [DW-1:0] t;
        r = '0;
        for (int j = SW - 1; j >= 0; j--) begin
            int idx;
            idx = ST + s * SW + j;
            t = d >> idx;
            r = {r[SW-2:0], (idx < DW) ? t[0] : 1'b0};
        end
        return r;
    endfunction

    function automatic logic [DW-1:0] rand_data();
        logic [DW-1:0] d;
        d = '0;
        for (int c = 0; c < (DW + 31) / 32; c++)
            d = (d << 32) | DW'($urandom);
        return d;
    endfunction

    task automatic check(input string tag, input logic [SW-1:0] act, input logic [SW-1:0] exp);
        vec_count++;
        if (act !== exp) begin
            miss_count++;
            $display("FAIL %s sel=%0d actual=%h expected=%h", tag, sel, act, exp);
        end
    endtask

    // Drive at falling edge, sample 1 ns later.
    task automatic apply(input logic [DW-1:0] d, input int s);
        @(negedge clk);
        data_in = d;
        sel     = SELW'(s);
        #1;
    endtask

    initial begin
        int unused;
        logic [DW-1:0] d;
        logic [DW-1:0] win;
        logic [SW-1:0] keep;
        unused = $urandom(32'd20240611);

        repeat (3) @(posedge clk);
        rst = 1'b0;
        #1;
        check("R4 reset idle", slice_out, '0);

        // R1: lane 0 takes bits 27..36, one-hot walk
        for (int j = 0; j < SW; j++) begin
            d = '0;
            d[ST + j] = 1'b1;
            apply(d, 0);
            check("R1 lane0 onehot", slice_out, SW'(1) << j);
        end

        // R2: straddling lane 22 with all-ones data
        apply('1, 22);
        check("R2 partial lane all-ones", slice_out, SW'(10'b0000000111));
        // R1: last full lane 21 with all-ones
        apply('1, 21);
        check("R1 last full lane", slice_out, '1);

        // R3: far lanes read zero with all-ones data
        for (int s = 23; s < NSEL; s++) begin
            apply('1, s);
            check("R3 far lane zero", slice_out, '0);
        end

        // R6: bits below START never appear
        d = '0;
        d[ST-1:0] = '1;
        for (int s = 0; s < NSEL; s++) begin
            apply(d, s);
            check("R6 below offset", slice_out, '0);
        end

        // R5: flip everything outside lane 5's window (bits 77..86)
        d = rand_data();
        apply(d, 5);
        keep = slice_out;
        check("R5 base", slice_out, ref_slice(d, 5));
        win = '0;
        win[ST + 5*SW +: SW] = '1;
        apply(d ^ ~win, 5);
        check("R5 outside bits ignored", slice_out, keep);

        // R7: mid-cycle change is visible before any clock edge
        @(negedge clk);
        d = rand_data();
        data_in = d;
        sel = SELW'(3);
        #1;
        check("R7 same-cycle sel3", slice_out, ref_slice(d, 3));
        #3;
        sel = SELW'(22);
        #1;
        check("R7 same-cycle sel22", slice_out, ref_slice(d, 22));

        // R4/R1/R2: random sweep, including known-value check
        for (int n = 0; n < 400; n++) begin
            int s;
            d = rand_data();
            s = (n < NSEL) ? n : int'($urandom % NSEL);
            apply(d, s);
            check($isunknown(slice_out) ? "R4 unknown output" : "R1 R2 random",
                  slice_out, ref_slice(d, s));
        end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vec_count, miss_count);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            miss_count++;
            $display("FAIL watchdog expired actual=hung expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", vec_count, miss_count);
            $finish;
        end
    end

endmodule